// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a multiplier peripheral that sits on a simple synchronous register port with 16-bit words. A 16-bit unit takes two operands. The address through which the first operand is written picks the arithmetic mode: unsigned product, signed product, unsigned running sum or signed running sum. The write of the second operand starts the operation. The result comes back as a low word and a high word, plus a mode-dependent extension word. Software may also write the result low word to seed the result and the accumulator with a starting value.

A second unit multiplies two 32-bit operands into a 64-bit product. Each operand is written in halves, and the high half of the second operand starts that product. The product is read back as four 16-bit words.

Each operation takes one clock. During that cycle the ready output is low, reads return the values from before the operation, and any write is dropped.

Top module: `mulacc_periph`

## Requirements
- R1: After reset every operand, result, accumulator and product reads 0x0000, ready is high, and the 16-bit mode is the unsigned product.
- R2: Word addresses 0, 1, 2 and 3 are aliases of the first 16-bit operand. A write through address k stores the value and selects a mode: 0 unsigned product, 1 signed product, 2 unsigned accumulate, 3 signed accumulate. A read at any of the four addresses returns the stored operand.
- R3: A write to address 4 stores the second operand and starts the operation. In the next cycle ready is low and all reads return the old values. In the cycle after that, ready is high and the new result is visible.
- R4: In the two product modes, the result becomes the 32-bit product and the accumulator is cleared. In the signed product mode both operands are sign-extended first.
- R5: In the two accumulate modes, the product (signed modes sign-extend both operands) is added to the accumulator modulo 2^32, and the result then equals the new accumulator.
- R6: The extension word at address 7 depends on the mode. In the unsigned product mode it reads 0x0000. In the signed product mode it reads 0xFFFF when result bit 31 is set, else 0x0000. In the unsigned accumulate mode it reads 0x0001 when the last add carried out of bit 31, else 0x0000. In the signed accumulate mode it reads 0xFFFF when the 33-bit signed sum of the last add was negative, else 0x0000.
- R7: A write to address 5 loads both the result and the accumulator with the value. The value is zero-extended in an unsigned mode and sign-extended in a signed mode. The write clears the carry, and in a signed mode the sign flag takes bit 15 of the value. Address 5 reads result bits 15:0 and address 6 reads result bits 31:16.
- R8: A write to address 8 (unsigned) or address 9 (signed) sets the first 32-bit operand to the zero-extended value and selects the 32-bit mode. A write to address 10 replaces bits 31:16 of that operand and keeps bits 15:0. Addresses 8 and 9 read the low half and address 10 reads the high half.
- R9: A write to address 11 sets the second 32-bit operand to the zero-extended value. A write to address 12 replaces its bits 31:16 and starts the 64-bit product, with the same one-cycle ready-low window as R3. Addresses 11 and 12 read the two halves.
- R10: Addresses 13 to 16 read the 64-bit product, least significant word first. In signed mode the product is the two's-complement product of the sign-extended operands, so the top word carries the sign. In unsigned mode the top word is zero-extended.
- R11: Any write made while ready is low is ignored.
- R12: Reads from unused addresses 17 to 31 return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Word address of the register |
| busWrData | input | 16 | Write data |
| busWe | input | 1 | Write enable, sampled at the clock edge |
| rdData | output | 16 | Read data for busAddr (combinational) |
| ready | output | 1 | High when no operation is in flight |

## Verification
The 16-bit unit is driven with all-ones unsigned operands, which shows the full-width product apart from a truncated one. A minus-one by three signed product shows sign extension apart from zero extension. A pair of back-to-back unsigned accumulates forces a carry out of bit 31, which shows up in the extension word.

A signed running sum is seeded with a negative preload and then crosses zero in both directions, so the extension word must follow the sign of the true sum. The 32-bit unit repeats one operand pair in signed and in unsigned mode, which tells the two top words apart. The cycle-level ready window and the dropping of a write made during it are checked at the read port.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;

  parameter int unsigned MA_DW = 16;
  parameter int unsigned MA_AW = 5;

  // Register word addresses; the op1 alias order is the mode encoding.
  localparam int unsigned A_OP1   = 0;
  localparam int unsigned A_OP2   = 4;
  localparam int unsigned A_RLO   = 5;
  localparam int unsigned A_RHI   = 6;
  localparam int unsigned A_EXT   = 7;
  localparam int unsigned A_ALO_U = 8;
  localparam int unsigned A_ALO_S = 9;
  localparam int unsigned A_AHI   = 10;
  localparam int unsigned A_BLO   = 11;
  localparam int unsigned A_BHI   = 12;
  localparam int unsigned A_P0    = 13;
  localparam int unsigned N_PW    = 4;

  typedef enum logic [1:0] {
    MD_UMUL = 2'd0,
    MD_SMUL = 2'd1,
    MD_UMAC = 2'd2,
    MD_SMAC = 2'd3
  } mode_e;

  typedef struct packed {
    logic  ldOp1;
    mode_e mode;
    logic  ldOp2;
    logic  preload;
    logic  run16;
    logic  ldALo;
    logic  sgnA;
    logic  ldAHi;
    logic  ldBLo;
    logic  ldBHi;
    logic  run32;
  } ctl_s;

endpackage

// File: rtl/mulacc_ctrl.sv
module mulacc_ctrl
  import mulacc_pkg::*;
#(
  parameter int ADDR_W = MA_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctl_s              ctl,
  output logic              ready
);

  logic pend16, pend32;
  logic take;

  assign ready = ~(pend16 | pend32);
  assign take  = busWe & ready;

  always_comb begin
    ctl       = '0;
    ctl.mode  = mode_e'(busAddr[1:0]);
    ctl.sgnA  = (busAddr == ADDR_W'(A_ALO_S));
    ctl.run16 = pend16;
    ctl.run32 = pend32;
    if (take) begin
      ctl.ldOp1   = (busAddr[ADDR_W-1:2] == '0);
      ctl.ldOp2   = (busAddr == ADDR_W'(A_OP2));
      ctl.preload = (busAddr == ADDR_W'(A_RLO));
      ctl.ldALo   = (busAddr == ADDR_W'(A_ALO_U)) || (busAddr == ADDR_W'(A_ALO_S));
      ctl.ldAHi   = (busAddr == ADDR_W'(A_AHI));
      ctl.ldBLo   = (busAddr == ADDR_W'(A_BLO));
      ctl.ldBHi   = (busAddr == ADDR_W'(A_BHI));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend16 <= 1'b0;
      pend32 <= 1'b0;
    end else begin
      pend16 <= take && (busAddr == ADDR_W'(A_OP2));
      pend32 <= take && (busAddr == ADDR_W'(A_BHI));
    end
  end

endmodule

// File: rtl/mulacc_dp16.sv
module mulacc_dp16
  import mulacc_pkg::*;
#(
  parameter int DW = MA_DW
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctl_s            ctl,
  input  logic [DW-1:0]   wrData,
  output logic [DW-1:0]   op1Q,
  output logic [DW-1:0]   op2Q,
  output logic [2*DW-1:0] resultQ,
  output logic [DW-1:0]   extQ
);

  localparam int RW = 2 * DW;

  mode_e         mode;
  logic [RW-1:0] acc;
  logic          carry, accNeg;
  logic          sgn, mac;
  logic [RW-1:0] xa, xb, prod, preVal;
  logic [RW:0]   sumU, sumS;

  assign sgn = mode[0];
  assign mac = mode[1];

  always_comb begin
    xa     = sgn ? {{DW{op1Q[DW-1]}}, op1Q} : {{DW{1'b0}}, op1Q};
    xb     = sgn ? {{DW{op2Q[DW-1]}}, op2Q} : {{DW{1'b0}}, op2Q};
    prod   = xa * xb;
    sumU   = {1'b0, acc} + {1'b0, prod};
    sumS   = {acc[RW-1], acc} + {prod[RW-1], prod};
    preVal = sgn ? {{DW{wrData[DW-1]}}, wrData} : {{DW{1'b0}}, wrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op1Q    <= '0;
      op2Q    <= '0;
      mode    <= MD_UMUL;
      resultQ <= '0;
      acc     <= '0;
      carry   <= 1'b0;
      accNeg  <= 1'b0;
    end else begin
      if (ctl.ldOp1) begin
        op1Q <= wrData;
        mode <= ctl.mode;
      end
      if (ctl.ldOp2) op2Q <= wrData;
      if (ctl.preload) begin
        resultQ <= preVal;
        acc     <= preVal;
        carry   <= 1'b0;
        accNeg  <= sgn & wrData[DW-1];
      end else if (ctl.run16) begin
        if (!mac) begin
          resultQ <= prod;
          acc     <= '0;
          carry   <= 1'b0;
          accNeg  <= 1'b0;
        end else if (sgn) begin
          resultQ <= sumS[RW-1:0];
          acc     <= sumS[RW-1:0];
          carry   <= 1'b0;
          accNeg  <= sumS[RW];
        end else begin
          resultQ <= sumU[RW-1:0];
          acc     <= sumU[RW-1:0];
          carry   <= sumU[RW];
          accNeg  <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    unique case (mode)
      MD_UMUL: extQ = '0;
      MD_SMUL: extQ = {DW{resultQ[RW-1]}};
      MD_UMAC: extQ = DW'(carry);
      MD_SMAC: extQ = {DW{accNeg}};
      default: extQ = '0;
    endcase
  end

endmodule

// File: rtl/mulacc_dp32.sv
module mulacc_dp32
  import mulacc_pkg::*;
#(
  parameter int DW = MA_DW
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctl_s            ctl,
  input  logic [DW-1:0]   wrData,
  output logic [2*DW-1:0] opAQ,
  output logic [2*DW-1:0] opBQ,
  output logic [4*DW-1:0] prodQ
);

  localparam int AW = 2 * DW;
  localparam int PW = 4 * DW;

  logic          sgnQ;
  logic [PW-1:0] ea, eb;

  always_comb begin
    ea = sgnQ ? {{AW{opAQ[AW-1]}}, opAQ} : {{AW{1'b0}}, opAQ};
    eb = sgnQ ? {{AW{opBQ[AW-1]}}, opBQ} : {{AW{1'b0}}, opBQ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAQ  <= '0;
      opBQ  <= '0;
      sgnQ  <= 1'b0;
      prodQ <= '0;
    end else begin
      if (ctl.ldALo) begin
        opAQ <= {{DW{1'b0}}, wrData};
        sgnQ <= ctl.sgnA;
      end
      if (ctl.ldAHi) opAQ[AW-1:DW] <= wrData;
      if (ctl.ldBLo) opBQ <= {{DW{1'b0}}, wrData};
      if (ctl.ldBHi) opBQ[AW-1:DW] <= wrData;
      if (ctl.run32) prodQ <= ea * eb;
    end
  end

endmodule

// File: rtl/mulacc_periph.sv
module mulacc_periph
  import mulacc_pkg::*;
#(
  parameter int ADDR_W = MA_AW,
  parameter int DW     = MA_DW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DW-1:0]     busWrData,
  input  logic              busWe,
  output logic [DW-1:0]     rdData,
  output logic              ready
);

  ctl_s            ctl;
  logic [DW-1:0]   op1Q, op2Q, extQ;
  logic [2*DW-1:0] resultQ, opAQ, opBQ;
  logic [4*DW-1:0] prodQ;

  mulacc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .ctl(ctl), .ready(ready)
  );

  mulacc_dp16 #(.DW(DW)) u_dp16 (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(busWrData),
    .op1Q(op1Q), .op2Q(op2Q), .resultQ(resultQ), .extQ(extQ)
  );

  mulacc_dp32 #(.DW(DW)) u_dp32 (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(busWrData),
    .opAQ(opAQ), .opBQ(opBQ), .prodQ(prodQ)
  );

  always_comb begin
    rdData = '0;
    if (busAddr[ADDR_W-1:2] == '0) begin
      rdData = op1Q;
    end else begin
      case (busAddr)
        ADDR_W'(A_OP2):   rdData = op2Q;
        ADDR_W'(A_RLO):   rdData = resultQ[DW-1:0];
        ADDR_W'(A_RHI):   rdData = resultQ[2*DW-1:DW];
        ADDR_W'(A_EXT):   rdData = extQ;
        ADDR_W'(A_ALO_U): rdData = opAQ[DW-1:0];
        ADDR_W'(A_ALO_S): rdData = opAQ[DW-1:0];
        ADDR_W'(A_AHI):   rdData = opAQ[2*DW-1:DW];
        ADDR_W'(A_BLO):   rdData = opBQ[DW-1:0];
        ADDR_W'(A_BHI):   rdData = opBQ[2*DW-1:DW];
        default:          rdData = '0;
      endcase
      for (int i = 0; i < N_PW; i++) begin
        if (busAddr == ADDR_W'(A_P0 + i)) rdData = prodQ[i*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/mulacc_chk.sv
module mulacc_chk
  import mulacc_pkg::*;
#(
  parameter int ADDR_W = MA_AW,
  parameter int DW     = MA_DW
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic              ready,
  input logic [DW-1:0]     op1Q,
  input logic [2*DW-1:0]   resultQ,
  input logic [4*DW-1:0]   prodQ
);

  logic trig;
  assign trig = ready && busWe &&
                ((busAddr == ADDR_W'(A_OP2)) || (busAddr == ADDR_W'(A_BHI)));

  p_busy_after_trig_r3: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> !ready);

  p_busy_one_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> ready);

  p_result_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> $stable(resultQ));

  p_prod_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> $stable(prodQ));

  p_busy_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> $stable(op1Q));

endmodule

bind mulacc_periph mulacc_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .ready(ready),
  .op1Q(op1Q), .resultQ(resultQ), .prodQ(prodQ)
);

// File: tb/mulacc_periph_tb.sv
module mulacc_periph_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic        busWe = 1'b0;
  logic [15:0] rdData;
  logic        ready;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [4:0]  a;
    logic [15:0] e;
    string       t;
  } item_t;
  item_t sbq[$];

  // model state
  logic [1:0]  mMode = 2'd0;
  logic [15:0] mOp1 = '0;
  logic [31:0] mAcc = '0, mRes = '0;
  logic        mCar = 1'b0, mNeg = 1'b0;
  logic [31:0] mA = '0, mB = '0;
  logic        mS = 1'b0;
  logic [63:0] mP = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mulacc_periph u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWe(busWe), .rdData(rdData), .ready(ready)
  );

  task automatic cmp(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        cmp(64'(rdData), 64'(it.e), it.t);
      end
    end
  end

  task automatic expRead(input logic [4:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    busAddr = a;
    sbq.push_back('{a, e, t});
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic trig(input logic [4:0] a, input logic [15:0] d,
                      input logic [4:0] holdA, input logic [15:0] holdV, input string t);
    @(negedge clk);
    busAddr = a; busWrData = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    cmp(64'(ready), 64'd0, {t, " ready low in op cycle"});
    busAddr = holdA;
    #1;
    cmp(64'(rdData), 64'(holdV), {t, " old value held while busy"});
    @(negedge clk);
    cmp(64'(ready), 64'd1, {t, " ready back"});
  endtask

  function automatic logic [15:0] extExp();
    case (mMode)
      2'd0: return 16'h0000;
      2'd1: return mRes[31] ? 16'hFFFF : 16'h0000;
      2'd2: return {15'b0, mCar};
      default: return mNeg ? 16'hFFFF : 16'h0000;
    endcase
  endfunction

  task automatic modelRun(input logic [15:0] v);
    logic [31:0] xa, xb, p;
    logic [32:0] s;
    xa = mMode[0] ? {{16{mOp1[15]}}, mOp1} : {16'b0, mOp1};
    xb = mMode[0] ? {{16{v[15]}}, v} : {16'b0, v};
    p = xa * xb;
    case (mMode)
      2'd0, 2'd1: begin mRes = p; mAcc = '0; mCar = 0; mNeg = 0; end
      2'd2: begin s = {1'b0, mAcc} + {1'b0, p}; mAcc = s[31:0]; mRes = mAcc; mCar = s[32]; mNeg = 0; end
      default: begin s = {mAcc[31], mAcc} + {p[31], p}; mAcc = s[31:0]; mRes = mAcc; mNeg = s[32]; mCar = 0; end
    endcase
  endtask

  task automatic checkRes(input string t);
    expRead(5'd5, mRes[15:0], {t, " result low"});
    expRead(5'd6, mRes[31:16], {t, " result high"});
    expRead(5'd7, extExp(), {"R6 ", t, " extension"});
  endtask

  task automatic setOp1(input logic [1:0] m, input logic [15:0] v);
    wr({3'b0, m}, v);
    mMode = m; mOp1 = v;
  endtask

  task automatic runOp2(input logic [15:0] v, input string t);
    logic [15:0] old;
    old = mRes[15:0];
    modelRun(v);
    trig(5'd4, v, 5'd5, old, "R3");
    checkRes(t);
  endtask

  task automatic preload(input logic [15:0] v, input string t);
    wr(5'd5, v);
    mRes = mMode[0] ? {{16{v[15]}}, v} : {16'b0, v};
    mAcc = mRes; mCar = 0; mNeg = mMode[0] & v[15];
    checkRes(t);
  endtask

  task automatic runBHi(input logic [15:0] v, input string t);
    logic [63:0] ea, eb;
    logic [15:0] old;
    old = mP[15:0];
    mB[31:16] = v;
    ea = mS ? {{32{mA[31]}}, mA} : {32'b0, mA};
    eb = mS ? {{32{mB[31]}}, mB} : {32'b0, mB};
    mP = ea * eb;
    trig(5'd12, v, 5'd13, old, "R9");
    for (int i = 0; i < 4; i++)
      expRead(5'(13 + i), mP[i*16 +: 16], {"R10 ", t});
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    cmp(64'(ready), 64'd1, "R1 ready after reset");
    expRead(5'd0, 16'h0000, "R1 op1 reset");
    expRead(5'd5, 16'h0000, "R1 result low reset");
    expRead(5'd6, 16'h0000, "R1 result high reset");
    expRead(5'd7, 16'h0000, "R1 extension reset");
    expRead(5'd16, 16'h0000, "R1 product top reset");

    // R2 alias store and readback
    setOp1(2'd0, 16'h1234);
    expRead(5'd2, 16'h1234, "R2 alias readback");
    expRead(5'd3, 16'h1234, "R2 alias readback");

    // R4 unsigned product, full width
    setOp1(2'd0, 16'hFFFF);
    runOp2(16'hFFFF, "R4 unsigned product");
    // R4 signed product, negative
    setOp1(2'd1, 16'hFFFF);
    runOp2(16'h0003, "R4 signed product negative");
    setOp1(2'd1, 16'h7FFF);
    runOp2(16'h7FFF, "R4 signed product positive");

    // R5 unsigned accumulate with carry out
    setOp1(2'd2, 16'hFFFF);
    runOp2(16'hFFFF, "R5 unsigned accumulate first");
    runOp2(16'hFFFF, "R5 unsigned accumulate carry");

    // R7 preload in unsigned mode then accumulate onto it
    preload(16'h8000, "R7 unsigned preload");
    setOp1(2'd2, 16'h0002);
    runOp2(16'h0003, "R5 accumulate after preload");

    // R7 signed preload, then signed accumulate crossing zero both ways
    setOp1(2'd3, 16'h0004);
    preload(16'hFFF0, "R7 signed preload");
    runOp2(16'h0005, "R5 signed accumulate up");
    runOp2(16'hFFFE, "R5 signed accumulate down");

    // R11 write during busy cycle is dropped
    modelRun(16'h0001);
    @(negedge clk);
    busAddr = 5'd4; busWrData = 16'h0001; busWe = 1'b1;
    @(negedge clk);
    cmp(64'(ready), 64'd0, "R11 busy window");
    busAddr = 5'd0; busWrData = 16'hAAAA;
    @(negedge clk);
    busWe = 1'b0;
    expRead(5'd1, mOp1, "R11 op1 unchanged after busy write");
    checkRes("R11 mode unchanged after busy write");

    // R8 32-bit operand halves
    wr(5'd8, 16'h1111); wr(5'd10, 16'h2222);
    expRead(5'd9, 16'h1111, "R8 low half kept");
    expRead(5'd10, 16'h2222, "R8 high half merged");

    // R9/R10 unsigned 32x32
    wr(5'd8, 16'hFFFF); mA = 32'h0000FFFF; mS = 0;
    wr(5'd10, 16'hFFFF); mA[31:16] = 16'hFFFF;
    wr(5'd11, 16'hFFFF); mB = 32'h0000FFFF;
    runBHi(16'hFFFF, "unsigned max product");

    // R9 low write clears high half
    wr(5'd11, 16'h0003); mB = 32'h00000003;
    expRead(5'd12, 16'h0000, "R9 low write clears high half");

    // R10 signed 32x32
    wr(5'd9, 16'hFFFE); mA = 32'h0000FFFE; mS = 1;
    wr(5'd10, 16'hFFFF); mA[31:16] = 16'hFFFF;
    runBHi(16'h0000, "signed product sign top word");

    // R10 same operands unsigned
    wr(5'd8, 16'hFFFE); mA = 32'h0000FFFE; mS = 0;
    wr(5'd10, 16'hFFFF); mA[31:16] = 16'hFFFF;
    runBHi(16'h0000, "unsigned product zero top word");

    // R12 unused addresses
    expRead(5'd17, 16'h0000, "R12 unused address");
    expRead(5'd31, 16'h0000, "R12 unused address");

    while (sbq.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule